// File: doc/BRIEF.md
# Delta-Correlating Prefetch Table

This block predicts upcoming cache misses from the pattern of address strides that each load instruction produces. A table, indexed by the program counter of the missing load, holds one entry per tracked load. Each entry keeps the block address of the load's last miss, a shift history of recent address deltas, and a count of how many of those deltas are valid. When a miss arrives for a tracked load, the new delta is pushed into that load's history. The block then looks for an earlier place in the history where the two newest deltas also appeared. If it finds one, it replays the deltas that came after that place, adding each to the current miss address to form a sequence of prefetch candidates.

Entries keep no record of what was last prefetched. Duplicate prefetches are avoided by probing instead. Each candidate is placed on a lookup port, and the surrounding logic answers in the same cycle with whether the block is already cached and whether it is already waiting in the prefetch queue. A candidate that hits either one is skipped. The others leave through a valid/ready port, at most one per cycle. The pattern comparison can run in exact mode, or in partial mode where the low `MASK_BITS` bits of every delta are ignored. Loads that are not yet tracked take the oldest entry, so replacement is first-in first-out.

Top module: `delta_prefetch_table`

## Requirements
- R1: After reset, `pf_valid` and `probe_valid` are 0, `miss_ready` is 1, and no load is tracked.
- R2: A miss whose PC is not in the table allocates the entry that has been allocated longest ago, with an empty history, and produces no candidate. An entry survives the next `ENTRIES-1` allocations and is replaced by the one after them. A PC is never held in two entries at once.
- R3: For a tracked PC, the delta is the miss block address minus the stored last address, and the stored last address becomes the miss address. A delta of zero is not stored, and it starts no search.
- R4: A delta that does not fit in a signed `DELTA_W`-bit value empties that entry's history and produces no candidate. It takes three more stored deltas before that entry can predict again.
- R5: With the history numbered 0 (newest) upward, the block searches for the smallest j ≥ 1 such that deltas (j+1, j) equal the pair (1, 0), using only valid deltas. On a match it emits, in order, the running sums of deltas j-1 down to 0 added to the miss address. With no match it emits nothing.
- R6: When `partial_en` is 1, two deltas are treated as equal if they agree once their low `MASK_BITS` bits are discarded. When `partial_en` is 0, all bits must agree.
- R7: A candidate for which `probe_in_cache` is 1 in the cycle it is probed is not emitted, and the replay moves on to the next candidate.
- R8: A candidate for which `probe_in_queue` is 1 in the cycle it is probed is not emitted, and the replay moves on to the next candidate.
- R9: While `pf_valid` is 1 and `pf_ready` is 0, `pf_addr` holds its value in the next cycle, so no candidate is lost or reordered under backpressure.
- R10: `miss_ready` is 0 whenever a search or replay is running, and `pf_valid` is never 1 while `miss_ready` is 1. A search takes fewer than `HIST` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| partial_en | input | 1 | 1 selects masked delta comparison |
| miss_valid | input | 1 | A cache miss is offered |
| miss_ready | output | 1 | Block idle and able to take a miss |
| miss_pc | input | PC_W | Program counter of the missing load |
| miss_addr | input | ADDR_W | Block address of the miss |
| probe_valid | output | 1 | A candidate is on the lookup port |
| probe_addr | output | ADDR_W | Candidate block address being probed |
| probe_in_cache | input | 1 | Same-cycle answer: candidate already cached |
| probe_in_queue | input | 1 | Same-cycle answer: candidate already queued |
| pf_valid | output | 1 | Prefetch candidate offered |
| pf_ready | input | 1 | Downstream accepts the candidate |
| pf_addr | output | ADDR_W | Prefetch block address |

## Verification
A wrong last address, a wrong delta count, or a shifted history does not show up on the miss that corrupts it. It shows up as a missing, extra, or misordered prefetch address on a later miss for the same PC, within the three misses needed to rebuild a pattern. The tests are therefore built as short miss sequences per PC. After every miss, the bench compares the full list of addresses emitted on the prefetch port. An allocation that lands on the wrong slot is exposed only once the FIFO pointer wraps, so one test counts allocations up to and just past the table size.

// File: rtl/delta_prefetch_table.sv
module delta_prefetch_table #(
  parameter int PC_W      = 32,
  parameter int ADDR_W    = 32,
  parameter int DELTA_W   = 16,
  parameter int HIST      = 16,
  parameter int ENTRIES   = 97,
  parameter int MASK_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              partial_en,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [PC_W-1:0]   miss_pc,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              probe_valid,
  output logic [ADDR_W-1:0] probe_addr,
  input  logic              probe_in_cache,
  input  logic              probe_in_queue,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int CNT_W = $clog2(HIST + 1);
  localparam int POS_W = $clog2(HIST);
  localparam int EXT_W = ADDR_W - DELTA_W;

  typedef enum logic [1:0] {S_IDLE, S_SEARCH, S_REPLAY} state_t;

  logic [ENTRIES-1:0]               e_val;
  logic [PC_W-1:0]                  e_pc   [ENTRIES];
  logic [ADDR_W-1:0]                e_last [ENTRIES];
  logic [CNT_W-1:0]                 e_cnt  [ENTRIES];
  logic [HIST-1:0][DELTA_W-1:0]     e_hist [ENTRIES];

  state_t              st;
  logic [IDX_W-1:0]    cur, fifo_ptr, hit_idx;
  logic [POS_W-1:0]    jj, kk;
  logic [ADDR_W-1:0]   cand, diff, nxt;
  logic [ENTRIES-1:0]  hit_vec;
  logic                hit, fits, accept, srch_end, srch_hit, drop, advance;
  logic [CNT_W-1:0]    cnt_now, cnt_inc, cur_cnt;
  logic [HIST-1:0][DELTA_W-1:0] cur_hist;
  logic [DELTA_W-1:0]  step;
  logic [POS_W:0]      srch_cyc;

  function automatic logic dmatch(input logic pm, input logic [DELTA_W-1:0] a, input logic [DELTA_W-1:0] b);
    if (pm) return (a >> MASK_BITS) == (b >> MASK_BITS);
    return a == b;
  endfunction

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = e_val[g] && (e_pc[g] == miss_pc);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hit_vec[i]) hit_idx = IDX_W'(i);
  end

  assign hit        = |hit_vec;
  assign miss_ready = (st == S_IDLE);
  assign accept     = miss_valid && miss_ready;
  assign diff       = miss_addr - e_last[hit_idx];
  assign fits       = (diff[ADDR_W-1:DELTA_W-1] == '0) || (diff[ADDR_W-1:DELTA_W-1] == '1);
  assign cnt_now    = e_cnt[hit_idx];
  assign cnt_inc    = (cnt_now == CNT_W'(HIST)) ? cnt_now : cnt_now + 1'b1;

  assign cur_hist = e_hist[cur];
  assign cur_cnt  = e_cnt[cur];
  assign srch_end = (int'(jj) + 1) >= int'(cur_cnt);
  assign srch_hit = dmatch(partial_en, cur_hist[jj + POS_W'(1)], cur_hist[1]) &&
                    dmatch(partial_en, cur_hist[jj], cur_hist[0]);

  assign step        = cur_hist[kk];
  assign nxt         = cand + {{EXT_W{step[DELTA_W-1]}}, step};
  assign probe_valid = (st == S_REPLAY);
  assign probe_addr  = nxt;
  assign drop        = probe_in_cache || probe_in_queue;
  assign pf_valid    = (st == S_REPLAY) && !drop;
  assign pf_addr     = nxt;
  assign advance     = (st == S_REPLAY) && (drop || pf_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur      <= '0;
      jj       <= '0;
      kk       <= '0;
      cand     <= '0;
      fifo_ptr <= '0;
      e_val    <= '0;
      for (int i = 0; i < ENTRIES; i++) e_cnt[i] <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          if (hit) begin
            if (diff != '0) begin
              if (!fits) e_cnt[hit_idx] <= '0;
              else begin
                e_cnt[hit_idx] <= cnt_inc;
                st   <= S_SEARCH;
                cur  <= hit_idx;
                jj   <= POS_W'(1);
                cand <= miss_addr;
              end
            end
          end else begin
            e_val[fifo_ptr] <= 1'b1;
            e_cnt[fifo_ptr] <= '0;
            fifo_ptr <= (fifo_ptr == IDX_W'(ENTRIES - 1)) ? '0 : fifo_ptr + 1'b1;
          end
        end
        S_SEARCH: begin
          if (srch_end) st <= S_IDLE;
          else if (srch_hit) begin
            kk <= jj - 1'b1;
            st <= S_REPLAY;
          end else jj <= jj + 1'b1;
        end
        S_REPLAY: if (advance) begin
          cand <= nxt;
          if (kk == '0) st <= S_IDLE;
          else kk <= kk - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      if (hit) begin
        e_last[hit_idx] <= miss_addr;
        if (diff != '0 && fits)
          e_hist[hit_idx] <= {e_hist[hit_idx][HIST-2:0], diff[DELTA_W-1:0]};
      end else begin
        e_pc[fifo_ptr]   <= miss_pc;
        e_last[fifo_ptr] <= miss_addr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || st != S_SEARCH) srch_cyc <= '0;
    else srch_cyc <= srch_cyc + 1'b1;
  end

  // R2
  pc_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |-> $onehot0(hit_vec));

  // R2
  alloc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit) |=> miss_ready);

  // R3
  zero_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit && diff == '0) |=> miss_ready);

  // R7 R8
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (!probe_in_cache && !probe_in_queue));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |=> (pf_addr == $past(pf_addr)));

  // R10
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> !miss_ready);

  // R10
  search_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SEARCH) |-> (srch_cyc < (POS_W+1)'(HIST)));

endmodule

// File: tb/delta_prefetch_table_tb.sv
module delta_prefetch_table_tb;
  localparam int N_ENT = 8;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        partial_en = 0;
  logic        miss_valid = 0;
  logic        miss_ready;
  logic [31:0] miss_pc = '0;
  logic [31:0] miss_addr = '0;
  logic        probe_valid;
  logic [31:0] probe_addr;
  logic        probe_in_cache, probe_in_queue;
  logic        pf_valid;
  logic        pf_ready = 1;
  logic [31:0] pf_addr;

  int checks = 0, errors = 0, cycles = 0;
  logic        bp_en = 0;
  logic [31:0] cache_set [4];
  logic [31:0] queue_set [4];
  logic [31:0] pf_log [32];
  int          pf_n = 0, hold_err = 0, busy_err = 0;
  logic        stall_prev = 0;
  logic [31:0] stall_addr = '0;

  always #5 clk = ~clk;

  delta_prefetch_table #(.ENTRIES(N_ENT)) u_dut (
    .clk(clk), .rst_n(rst_n), .partial_en(partial_en),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_pc(miss_pc), .miss_addr(miss_addr),
    .probe_valid(probe_valid), .probe_addr(probe_addr),
    .probe_in_cache(probe_in_cache), .probe_in_queue(probe_in_queue),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
  );

  always_comb begin
    probe_in_cache = 1'b0;
    probe_in_queue = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (cache_set[i] == probe_addr) probe_in_cache = 1'b1;
      if (queue_set[i] == probe_addr) probe_in_queue = 1'b1;
    end
  end

  always @(posedge clk) begin
    #1;
    pf_ready = bp_en ? ~pf_ready : 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (pf_valid && miss_ready) busy_err++;
      if (stall_prev && pf_valid && pf_addr != stall_addr) hold_err++;
      if (pf_valid && pf_ready) begin
        if (pf_n < 32) pf_log[pf_n] = pf_addr;
        pf_n++;
      end
      stall_prev = pf_valid && !pf_ready;
      stall_addr = pf_addr;
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, cycles %0d expected < %0d", cycles, 100000);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expect_pf(input string tag, input int n,
                           input logic [31:0] e0 = 0, input logic [31:0] e1 = 0, input logic [31:0] e2 = 0);
    checks++;
    if (pf_n != n) begin
      errors++;
      $display("FAIL %s: prefetch count %0d expected %0d", tag, pf_n, n);
    end else begin
      for (int i = 0; i < n; i++) begin
        logic [31:0] e;
        e = (i == 0) ? e0 : (i == 1) ? e1 : e2;
        chk(tag, pf_log[i], e);
      end
    end
    pf_n = 0;
  endtask

  task automatic miss(input logic [31:0] pc, input logic [31:0] a);
    @(posedge clk); #1;
    miss_valid = 1; miss_pc = pc; miss_addr = a;
    @(negedge clk);
    while (!miss_ready) @(negedge clk);
    @(posedge clk); #1;
    miss_valid = 0;
    @(negedge clk);
    while (!miss_ready) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 pf_valid", {31'b0, pf_valid}, 32'd0);
    chk("R1 miss_ready", {31'b0, miss_ready}, 32'd1);
    chk("R1 probe_valid", {31'b0, probe_valid}, 32'd0);
  endtask

  task automatic t_stride();
    miss(32'h10, 32'd100); expect_pf("R2 alloc quiet", 0);
    miss(32'h10, 32'd104); expect_pf("R5 one delta", 0);
    miss(32'h10, 32'd108); expect_pf("R5 two deltas", 0);
    miss(32'h10, 32'd112); expect_pf("R5 stride", 1, 32'd116);
  endtask

  task automatic t_zero();
    miss(32'h10, 32'd112); expect_pf("R3 zero delta", 0);
    miss(32'h10, 32'd116); expect_pf("R3 history untouched", 1, 32'd120);
  endtask

  task automatic t_pattern(input logic [31:0] pc, input logic [31:0] b, input string tag);
    miss(pc, b);      expect_pf(tag, 0);
    miss(pc, b + 1);  expect_pf(tag, 0);
    miss(pc, b + 3);  expect_pf(tag, 0);
    miss(pc, b + 6);  expect_pf(tag, 0);
    miss(pc, b + 7);  expect_pf(tag, 0);
    miss(pc, b + 9);  expect_pf(tag, 3, b + 12, b + 13, b + 15);
    miss(pc, b + 12); expect_pf(tag, 3, b + 13, b + 15, b + 18);
  endtask

  task automatic t_backpressure();
    bp_en = 1;
    t_pattern(32'h30, 32'd2000, "R9 backpressure order");
    bp_en = 0;
    checks++;
    if (hold_err != 0) begin errors++; $display("FAIL R9: address changes while stalled %0d expected 0", hold_err); end
    checks++;
    if (busy_err != 0) begin errors++; $display("FAIL R10: prefetch while idle %0d expected 0", busy_err); end
  endtask

  task automatic t_partial();
    partial_en = 1;
    miss(32'h40, 32'h4000); miss(32'h40, 32'h4100); miss(32'h40, 32'h42F0);
    expect_pf("R6 partial warmup", 0);
    miss(32'h40, 32'h43F5); expect_pf("R6 masked match", 1, 32'h44FA);
    partial_en = 0;
    miss(32'h41, 32'h4000); miss(32'h41, 32'h4100); miss(32'h41, 32'h42F0);
    miss(32'h41, 32'h43F5); expect_pf("R6 exact no match", 0);
  endtask

  task automatic t_drop();
    miss(32'h50, 32'd1000); miss(32'h50, 32'd1001); miss(32'h50, 32'd1003);
    miss(32'h50, 32'd1006); miss(32'h50, 32'd1007); expect_pf("R7 warmup", 0);
    miss(32'h50, 32'd1009); expect_pf("R7 before filter", 3, 32'd1012, 32'd1013, 32'd1015);
    cache_set[0] = 32'd1013;
    queue_set[0] = 32'd1015;
    miss(32'h50, 32'd1012); expect_pf("R7 R8 cache and queue drop", 1, 32'd1018);
    cache_set[0] = 32'hFFFF_FFFF;
    queue_set[0] = 32'hFFFF_FFFF;
  endtask

  task automatic t_overflow();
    miss(32'h60, 32'h100); miss(32'h60, 32'h104); miss(32'h60, 32'h108);
    miss(32'h60, 32'h10C); expect_pf("R4 before", 1, 32'h110);
    miss(32'h60, 32'h10010C); expect_pf("R4 overflow quiet", 0);
    miss(32'h60, 32'h100110); miss(32'h60, 32'h100114); expect_pf("R4 history cleared", 0);
    miss(32'h60, 32'h100118); expect_pf("R4 relearned", 1, 32'h10011C);
  endtask

  task automatic t_evict();
    miss(32'h70, 32'd5000); miss(32'h70, 32'd5004); miss(32'h70, 32'd5008);
    for (int i = 0; i < N_ENT - 1; i++) miss(32'h100 + i, 32'd9000 + 64 * i);
    expect_pf("R2 fresh allocations quiet", 0);
    miss(32'h70, 32'd5012); expect_pf("R2 entry retained", 1, 32'd5016);
    miss(32'h200, 32'd7000);
    miss(32'h70, 32'd5016); miss(32'h70, 32'd5020); miss(32'h70, 32'd5024);
    expect_pf("R2 entry evicted", 0);
    miss(32'h70, 32'd5028); expect_pf("R2 reallocated", 1, 32'd5032);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      cache_set[i] = 32'hFFFF_FFFF;
      queue_set[i] = 32'hFFFF_FFFF;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_stride();
    t_zero();
    t_pattern(32'h20, 32'd0, "R5 order");
    t_backpressure();
    t_partial();
    t_drop();
    t_overflow();
    t_evict();
    summary();
    $finish;
  end
endmodule